// File: doc/BRIEF.md
# Half-Word Pairing Bridge for a 16-bit Host Bus

This bridge joins a 16-bit host processor bus to a 32-bit internal register file. The host moves every 32-bit word as two 16-bit accesses, one to the lower half and one to the upper half, and the bridge turns each such pair into one 32-bit register operation. Writes are collected: the first half is held, and a single 32-bit register write is issued once the matching other half arrives. Reads are split: the first half triggers one 32-bit register read, the whole value is kept as a snapshot, and the second half is served from that snapshot so both halves belong to the same register value.

The halves may arrive in either order. Both halves of a pair must use the same word address, meaning every address bit above the half-select bit. A repeated write to the same half throws the pending pair away. A repeated read from the same half returns invalid data and restarts the read pairing. If the word address changes between the halves, the earlier half is dropped and the current access becomes a new first half. Read pairing and write pairing are tracked independently of each other. Register decode and byte-lane reordering are handled elsewhere.

Top module: `hbus_word_pair`

## Requirements
- R1: After synchronous reset, `reg_wr_en` is 0, `hb_rdata` is 0, and no half of either pairing is pending.
- R2: Two host writes to opposite halves of the same word, in either order, produce exactly one `reg_wr_en` pulse lasting one cycle. The pulse comes in the cycle after the second strobe and carries `reg_wr_addr` = `hb_addr[ADDR_W-1:2]`. In `reg_wr_data`, the half written with `hb_addr[1]`=0 occupies bits [15:0] and the half written with `hb_addr[1]`=1 occupies bits [31:16].
- R3: A single write half on its own causes no register write.
- R4: A second write to the same half as a pending first half discards both halves. No register write is issued, and the next write starts a new pair.
- R5: A write to a different word address while a write half is pending drops the pending half. The current write is then taken as a new first half.
- R6: A read that starts a pair raises `reg_rd_en` in the same cycle as its strobe, with `reg_rd_addr` = `hb_addr[ADDR_W-1:2]`. In the next cycle, `hb_rdata` shows the selected half of `reg_rd_data`: bits [15:0] when `hb_addr[1]`=0 and bits [31:16] when it is 1.
- R7: A read of the other half of the same word, following a first half, does not raise `reg_rd_en`. It returns that half from the snapshot taken on the first half, even if the register has changed since then.
- R8: A second read of the same half as the pending first half raises no `reg_rd_en`, returns 0 on `hb_rdata` in the next cycle, and clears the read pairing, so the next read is a first half.
- R9: A read from a different word address while a read half is pending is handled as a new first half, including a new register read.
- R10: Read pairing is not disturbed by writes and write pairing is not disturbed by reads. Strobes with `hb_cs` low are ignored.
- R11: `hb_rdata` holds its value in every cycle that follows a cycle with no qualified read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_cs | input | 1 | Host chip select, qualifies the strobes |
| hb_rd | input | 1 | Host read strobe, one cycle per access |
| hb_wr | input | 1 | Host write strobe, one cycle per access |
| hb_addr | input | ADDR_W-1 | Host half-word address; bit 1 selects the half, bits above give the word |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data, valid from the cycle after a read strobe |
| reg_wr_en | output | 1 | 32-bit register write enable |
| reg_wr_addr | output | ADDR_W-2 | Register write word address |
| reg_wr_data | output | 32 | Register write data |
| reg_rd_en | output | 1 | 32-bit register read enable |
| reg_rd_addr | output | ADDR_W-2 | Register read word address |
| reg_rd_data | input | 32 | Register read data, same cycle as `reg_rd_en` |

## Verification
The hardest case to reach is a read pair where the register changes between the two halves, combined with a write pair woven between those halves. This is the only way to tell a snapshot from a fresh read, and the only way to show that the two pairing trackers are truly separate. The bench changes its register model directly between the first and second read half, then interleaves a full write pair. It also runs a long random phase restricted to four word addresses, so that same-half repeats, word changes and cross-interleaving come up often, and it compares every output against a behavioural model on every cycle.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic  rd;
        logic  wr;
        half_e half;
    } acc_s;

    function automatic logic [31:0] join_halves(half_e first_h, logic [15:0] first_d,
                                                logic [15:0] second_d);
        return (first_h == HALF_LO) ? {second_d, first_d} : {first_d, second_d};
    endfunction

    function automatic logic [15:0] pick_half(logic [31:0] w, half_e h);
        return (h == HALF_HI) ? w[31:16] : w[15:0];
    endfunction

endpackage

// File: rtl/hbp_decode.sv
module hbp_decode
    import hbp_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int DW_W  = ADDR_W - 2
) (
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:1] addr,
    output acc_s              acc,
    output logic [DW_W-1:0]   dword
);
    always_comb begin
        acc.rd   = cs & rd;
        acc.wr   = cs & wr;
        acc.half = half_e'(addr[1]);
        dword    = addr[ADDR_W-1:2];
    end
endmodule

// File: rtl/hbp_wr_pair.sv
module hbp_wr_pair
    import hbp_pkg::*;
#(
    parameter int DW_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_wr,
    input  half_e           half,
    input  logic [DW_W-1:0] dword,
    input  logic [15:0]     wdata,
    output logic            wr_en,
    output logic [DW_W-1:0] wr_addr,
    output logic [31:0]     wr_data
);
    logic            pend_q;
    half_e           half_q;
    logic [DW_W-1:0] dw_q;
    logic [15:0]     data_q;
    logic            same_dw;

    assign same_dw = pend_q && (dw_q == dword);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            half_q  <= HALF_LO;
            dw_q    <= '0;
            data_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (acc_wr) begin
                if (same_dw && half_q != half) begin
                    wr_en   <= 1'b1;
                    wr_addr <= dword;
                    wr_data <= join_halves(half_q, data_q, wdata);
                    pend_q  <= 1'b0;
                end else if (same_dw) begin
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= 1'b1;
                    half_q <= half;
                    dw_q   <= dword;
                    data_q <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/hbp_rd_pair.sv
module hbp_rd_pair
    import hbp_pkg::*;
#(
    parameter int DW_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_rd,
    input  half_e           half,
    input  logic [DW_W-1:0] dword,
    output logic            rd_en,
    output logic [DW_W-1:0] rd_addr,
    input  logic [31:0]     rd_data,
    output logic [15:0]     rdata
);
    logic            pend_q;
    half_e           half_q;
    logic [DW_W-1:0] dw_q;
    logic [31:0]     snap_q;
    logic            match_dw, is_second, is_repeat;

    always_comb begin
        match_dw  = acc_rd && pend_q && (dw_q == dword);
        is_second = match_dw && (half_q != half);
        is_repeat = match_dw && (half_q == half);
        rd_en     = acc_rd && !match_dw;
        rd_addr   = dword;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            half_q <= HALF_LO;
            dw_q   <= '0;
            snap_q <= '0;
            rdata  <= '0;
        end else if (is_second) begin
            rdata  <= pick_half(snap_q, half);
            pend_q <= 1'b0;
        end else if (is_repeat) begin
            rdata  <= '0;
            pend_q <= 1'b0;
        end else if (rd_en) begin
            snap_q <= rd_data;
            rdata  <= pick_half(rd_data, half);
            pend_q <= 1'b1;
            half_q <= half;
            dw_q   <= dword;
        end
    end
endmodule

// File: rtl/hbus_word_pair.sv
module hbus_word_pair
    import hbp_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int DW_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hb_cs,
    input  logic              hb_rd,
    input  logic              hb_wr,
    input  logic [ADDR_W-1:1] hb_addr,
    input  logic [15:0]       hb_wdata,
    output logic [15:0]       hb_rdata,
    output logic              reg_wr_en,
    output logic [DW_W-1:0]   reg_wr_addr,
    output logic [31:0]       reg_wr_data,
    output logic              reg_rd_en,
    output logic [DW_W-1:0]   reg_rd_addr,
    input  logic [31:0]       reg_rd_data
);
    acc_s            acc;
    logic [DW_W-1:0] dword;

    hbp_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cs    (hb_cs),
        .rd    (hb_rd),
        .wr    (hb_wr),
        .addr  (hb_addr),
        .acc   (acc),
        .dword (dword)
    );

    hbp_wr_pair #(.DW_W(DW_W)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .acc_wr  (acc.wr),
        .half    (acc.half),
        .dword   (dword),
        .wdata   (hb_wdata),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data)
    );

    hbp_rd_pair #(.DW_W(DW_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .acc_rd  (acc.rd),
        .half    (acc.half),
        .dword   (dword),
        .rd_en   (reg_rd_en),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .rdata   (hb_rdata)
    );
endmodule

// File: rtl/hbp_checks.sv
module hbp_checks #(
    parameter int ADDR_W = 8,
    localparam int DW_W  = ADDR_W - 2
) (
    input logic              clk,
    input logic              rst,
    input logic              hb_cs,
    input logic              hb_rd,
    input logic              hb_wr,
    input logic [ADDR_W-1:1] hb_addr,
    input logic [15:0]       hb_rdata,
    input logic              reg_wr_en,
    input logic [DW_W-1:0]   reg_wr_addr,
    input logic              reg_rd_en,
    input logic [DW_W-1:0]   reg_rd_addr
);
    logic rd_q;
    assign rd_q = hb_cs && hb_rd;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!reg_wr_en && hb_rdata == 16'h0));

    assert_wr_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    assert_wr_addr_R2: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> reg_wr_addr == $past(hb_addr[ADDR_W-1:2]));

    assert_wr_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> $past(hb_cs && hb_wr));

    assert_rd_only_on_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |-> rd_q);

    assert_rd_addr_R6: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |-> reg_rd_addr == hb_addr[ADDR_W-1:2]);

    assert_second_half_no_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_q && $past(rd_q) && $past(reg_rd_en)
         && hb_addr[ADDR_W-1:2] == $past(hb_addr[ADDR_W-1:2])
         && hb_addr[1] != $past(hb_addr[1])) |-> !reg_rd_en);

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_q) |-> $stable(hb_rdata));
endmodule

bind hbus_word_pair hbp_checks #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hb_cs       (hb_cs),
    .hb_rd       (hb_rd),
    .hb_wr       (hb_wr),
    .hb_addr     (hb_addr),
    .hb_rdata    (hb_rdata),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_rd_en   (reg_rd_en),
    .reg_rd_addr (reg_rd_addr)
);

// File: tb/hbus_word_pair_tb.sv
module hbus_word_pair_tb;
    localparam int ADDR_W = 8;
    localparam int DW_W   = ADDR_W - 2;
    localparam int NWORDS = 1 << DW_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hb_cs = 1'b0, hb_rd = 1'b0, hb_wr = 1'b0;
    logic [ADDR_W-1:1] hb_addr = '0;
    logic [15:0]       hb_wdata = '0;
    logic [15:0]       hb_rdata;
    logic              reg_wr_en, reg_rd_en;
    logic [DW_W-1:0]   reg_wr_addr, reg_rd_addr;
    logic [31:0]       reg_wr_data, reg_rd_data;
    logic [31:0]       mem [NWORDS];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign reg_rd_data = mem[reg_rd_addr];

    hbus_word_pair #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .hb_cs(hb_cs), .hb_rd(hb_rd), .hb_wr(hb_wr),
        .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
    );

    // reference model state
    bit          wp = 0, wh = 0, rp = 0, rh = 0;
    int          wdw = 0, rdw = 0;
    logic [15:0] wd = '0;
    logic [31:0] snap = '0;
    logic        e_wen = 0;
    int          e_waddr = 0;
    logic [31:0] e_wdata = '0;
    logic [15:0] e_rdata = '0;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit cs, input bit rd, input bit wr,
                        input int a, input logic [15:0] d);
        int dw;
        bit h, aw, ar, r_sec, r_rep, r_first;
        hb_cs = cs; hb_rd = rd; hb_wr = wr;
        hb_addr = (ADDR_W-1)'(a); hb_wdata = d;
        #1;
        dw = a >> 1;
        h  = a[0];
        aw = cs && wr;
        ar = cs && rd;
        r_sec   = ar && rp && rdw == dw && rh != h;
        r_rep   = ar && rp && rdw == dw && rh == h;
        r_first = ar && !r_sec && !r_rep;
        chk(tag, "reg_rd_en", 32'(reg_rd_en), 32'(r_first));
        if (r_first) chk(tag, "reg_rd_addr", 32'(reg_rd_addr), 32'(dw));
        e_wen = 0;
        if (aw) begin
            if (wp && wdw == dw && wh != h) begin
                e_wen = 1; e_waddr = dw;
                e_wdata = wh ? {wd, d} : {d, wd};
                wp = 0;
            end else if (wp && wdw == dw) begin
                wp = 0;
            end else begin
                wp = 1; wh = h; wdw = dw; wd = d;
            end
        end
        if (r_sec) begin
            e_rdata = h ? snap[31:16] : snap[15:0]; rp = 0;
        end else if (r_rep) begin
            e_rdata = '0; rp = 0;
        end else if (r_first) begin
            snap = mem[dw];
            e_rdata = h ? snap[31:16] : snap[15:0];
            rp = 1; rh = h; rdw = dw;
        end
        @(posedge clk);
        #1;
        hb_cs = 0; hb_rd = 0; hb_wr = 0;
        @(negedge clk);
        chk(tag, "reg_wr_en", 32'(reg_wr_en), 32'(e_wen));
        if (e_wen) begin
            chk(tag, "reg_wr_addr", 32'(reg_wr_addr), 32'(e_waddr));
            chk(tag, "reg_wr_data", reg_wr_data, e_wdata);
        end
        chk(tag, "hb_rdata", 32'(hb_rdata), 32'(e_rdata));
    endtask

    // half-word address from word index and half
    function automatic int ha(int w, int h);
        return (w << 1) | h;
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NWORDS; i++) mem[i] = 32'h1000_0001 * (i + 3) ^ 32'hA5C3_0F96;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1", "reg_wr_en", 32'(reg_wr_en), 32'h0);
        chk("R1", "hb_rdata", 32'(hb_rdata), 32'h0);
        step("R1", 0, 0, 0, 0, '0);

        // write pairs, both orders
        step("R3", 1, 0, 1, ha(2, 0), 16'h1111);
        step("R3", 0, 0, 0, 0, '0);
        step("R2", 1, 0, 1, ha(2, 1), 16'h2222);
        step("R2", 1, 0, 1, ha(5, 1), 16'hAAAA);
        step("R2", 1, 0, 1, ha(5, 0), 16'hBBBB);
        // same-half repeat then good pair
        step("R4", 1, 0, 1, ha(7, 0), 16'h0101);
        step("R4", 1, 0, 1, ha(7, 0), 16'h0202);
        step("R4", 1, 0, 1, ha(7, 1), 16'h0303);
        step("R4", 1, 0, 1, ha(7, 0), 16'h0404);
        // word change between halves
        step("R5", 1, 0, 1, ha(3, 0), 16'h3333);
        step("R5", 1, 0, 1, ha(9, 1), 16'h9999);
        step("R5", 1, 0, 1, ha(9, 0), 16'h9090);
        // chip select low ignored
        step("R10", 0, 0, 1, ha(4, 0), 16'hDEAD);
        step("R10", 0, 1, 0, ha(4, 1), '0);
        step("R10", 1, 0, 1, ha(4, 1), 16'hBEEF);
        step("R10", 0, 0, 1, ha(4, 0), 16'hFFFF);
        step("R10", 1, 0, 1, ha(4, 0), 16'hCAFE);

        // read first half, change register, read second half from snapshot
        step("R6", 1, 1, 0, ha(6, 1), '0);
        mem[6] = 32'h7777_8888;
        step("R7", 1, 1, 0, ha(6, 0), '0);
        step("R11", 0, 0, 0, 0, '0);
        step("R11", 1, 0, 1, ha(1, 0), 16'h5555);
        // same-half repeat read
        step("R8", 1, 1, 0, ha(10, 0), '0);
        step("R8", 1, 1, 0, ha(10, 0), '0);
        step("R8", 1, 1, 0, ha(10, 0), '0);
        step("R8", 1, 1, 0, ha(10, 1), '0);
        // word change between read halves
        step("R9", 1, 1, 0, ha(11, 0), '0);
        step("R9", 1, 1, 0, ha(12, 1), '0);
        step("R9", 1, 1, 0, ha(12, 0), '0);
        // interleaved write pair inside a read pair
        step("R10", 1, 1, 0, ha(13, 0), '0);
        mem[13] = 32'h1234_5678;
        step("R10", 1, 0, 1, ha(14, 1), 16'h4141);
        step("R10", 1, 0, 1, ha(14, 0), 16'h4242);
        step("R10", 1, 1, 0, ha(13, 1), '0);

        // random mixed traffic on a few words
        for (int n = 0; n < 2000; n++) begin
            int op = $urandom_range(0, 5);
            int a  = ha($urandom_range(0, 3), $urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) mem[$urandom_range(0, 3)] = $urandom;
            case (op)
                0: step("R10", 0, 0, 0, a, '0);
                1, 2: step("R2", 1, 0, 1, a, 16'($urandom));
                3, 4: step("R8", 1, 1, 0, a, '0);
                default: step("R10", $urandom_range(0, 1), 1, 1, a, 16'($urandom));
            endcase
        end

        rst = 1;
        @(negedge clk);
        rst = 0;
        wp = 0; rp = 0; e_rdata = '0;
        chk("R1", "hb_rdata", 32'(hb_rdata), 32'h0);
        step("R1", 1, 0, 1, ha(2, 1), 16'h6666);
        step("R1", 0, 0, 0, 0, '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule